// File: doc/BRIEF.md
# Protected Page Access Checker

This block decides whether a memory access to a protected physical page may proceed. It keeps a small direct-mapped table with one entry per protected page slot. Each entry names the isolated context that owns the page, the virtual page the page must be reached through, read/write/execute rights, a page kind and a valid flag. Every request carries the physical page, the virtual page, the identity of the requesting context, whether the requester is running inside an isolated context, its privilege level and the access kind. The block answers with a grant, or with a fault and a fault code.

The answer always comes a fixed single cycle after the request. Physical pages outside the protected window are not looked up and are always granted. Table entries are loaded through a separate update port that higher-privileged software drives. Nothing on the request side, privilege included, can turn a fault into a grant.

Top module: `pg_own_check`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise; it is low after reset.
- R2: A request whose physical page lies outside [`PROT_BASE`, `PROT_BASE+PROT_PAGES`) is granted with fault code 0, whatever the table holds.
- R3: A protected request whose table slot (index = low `IDX_W` bits of the physical page) is invalid, or whose stored tag (remaining upper bits) differs, faults with code 1.
- R4: A protected request whose `req_in_encl` is 0, or whose requester identity differs from the stored owner, faults with code 2.
- R5: A protected request whose virtual page differs from the stored virtual page faults with code 3.
- R6: Access kind 2'b00 read needs perm bit 0, 2'b01 write needs perm bit 1, 2'b10 execute needs perm bit 2; kind 2'b11 is never allowed. A disallowed kind faults with code 4.
- R7: Page kind 2'b00 is a regular page; any other kind (2'b01 control structure, 2'b10 trimmed, 2'b11) faults with code 5.
- R8: When several fault conditions apply, the lowest code is reported.
- R9: A protected request that passes all checks is granted with fault code 0; a fault always carries a code from 1 to 5.
- R10: `req_priv` has no effect on the result.
- R11: An update on the update port writes the slot selected by `upd_ppn`; a request in the same cycle sees the old contents, requests from the next cycle on see the new contents.
- R12: Reset clears every valid flag, so every protected request faults with code 1 until its slot is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ppn | input | PPN_W | Physical page of the access |
| req_vpn | input | VPN_W | Virtual page of the access |
| req_eid | input | EID_W | Identity of the requesting context |
| req_in_encl | input | 1 | Requester runs inside an isolated context |
| req_priv | input | 2 | Requester privilege level (no effect) |
| req_acc | input | 2 | Access kind |
| upd_en | input | 1 | Table write strobe |
| upd_ppn | input | PPN_W | Physical page of the entry written |
| upd_valid | input | 1 | Valid flag written |
| upd_owner | input | EID_W | Owner identity written |
| upd_vpn | input | VPN_W | Expected virtual page written |
| upd_perm | input | 3 | Rights written: bit0 read, bit1 write, bit2 execute |
| upd_ptype | input | 2 | Page kind written |
| rsp_valid | output | 1 | Result strobe |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 3 | Fault code, 0 on grant |

## Verification
The bench builds the block with 8-bit physical and virtual pages, 3-bit identities, a 16-slot table and a protected window of 32 pages starting at 0x40. With these values two protected pages share each slot, so the tag comparison behind code 1 is reachable, and pages just below and just above the window exercise both bypass edges. Small identities and pages let the bench set up overlapping faults to check the priority order, and a write and a read of the same slot in one cycle to check update ordering.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam logic [2:0] FLT_NONE  = 3'd0;
  localparam logic [2:0] FLT_INVAL = 3'd1;
  localparam logic [2:0] FLT_OWNER = 3'd2;
  localparam logic [2:0] FLT_VADDR = 3'd3;
  localparam logic [2:0] FLT_PERM  = 3'd4;
  localparam logic [2:0] FLT_KIND  = 3'd5;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  localparam logic [1:0] KIND_REG = 2'b00;
  localparam logic [1:0] KIND_CTL = 2'b01;
  localparam logic [1:0] KIND_TRM = 2'b10;

  localparam int PERM_W = 3;
  localparam int KIND_W = 2;
endpackage

// File: rtl/pgc_rst_sync.sv
module pgc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pgc_table.sv
module pgc_table
  import pgc_pkg::*;
#(
  parameter int PPN_W = 8,
  parameter int VPN_W = 8,
  parameter int EID_W = 3,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PPN_W-1:0]      wr_ppn,
  input  logic                  wr_valid,
  input  logic [EID_W-1:0]      wr_owner,
  input  logic [VPN_W-1:0]      wr_vpn,
  input  logic [PERM_W-1:0]     wr_perm,
  input  logic [KIND_W-1:0]     wr_kind,
  input  logic [PPN_W-1:0]      rd_ppn,
  output logic                  rd_valid,
  output logic [PPN_W-IDX_W-1:0] rd_tag,
  output logic [EID_W-1:0]      rd_owner,
  output logic [VPN_W-1:0]      rd_vpn,
  output logic [PERM_W-1:0]     rd_perm,
  output logic [KIND_W-1:0]     rd_kind
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PPN_W - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [EID_W-1:0]  owner;
    logic [VPN_W-1:0]  vpn;
    logic [PERM_W-1:0] perm;
    logic [KIND_W-1:0] kind;
  } body_t;

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  body_t            wr_body;
  logic [DEPTH-1:0] vld_vec;
  body_t            body_arr [DEPTH];

  assign wr_idx = wr_ppn[IDX_W-1:0];
  assign rd_idx = rd_ppn[IDX_W-1:0];

  always_comb begin
    wr_body.tag   = wr_ppn[PPN_W-1:IDX_W];
    wr_body.owner = wr_owner;
    wr_body.vpn   = wr_vpn;
    wr_body.perm  = wr_perm;
    wr_body.kind  = wr_kind;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic  slot_we;
    logic  vld_q;
    logic  vld_d;
    body_t body_q;
    body_t body_d;

    always_comb begin
      slot_we = wr_en && (wr_idx == IDX_W'(e));
      vld_d   = slot_we ? wr_valid : vld_q;
      body_d  = slot_we ? wr_body  : body_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (slot_we) body_q <= body_d;
    end

    assign vld_vec[e]  = vld_q;
    assign body_arr[e] = body_q;
  end

  body_t rd_body;

  always_comb begin
    rd_body  = body_arr[rd_idx];
    rd_valid = vld_vec[rd_idx];
    rd_tag   = rd_body.tag;
    rd_owner = rd_body.owner;
    rd_vpn   = rd_body.vpn;
    rd_perm  = rd_body.perm;
    rd_kind  = rd_body.kind;
  end
endmodule

// File: rtl/pgc_eval.sv
module pgc_eval
  import pgc_pkg::*;
#(
  parameter int PPN_W      = 8,
  parameter int VPN_W      = 8,
  parameter int EID_W      = 3,
  parameter int IDX_W      = 4,
  parameter int PROT_BASE  = 64,
  parameter int PROT_PAGES = 32
) (
  input  logic [PPN_W-1:0]       req_ppn,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [EID_W-1:0]       req_eid,
  input  logic                   req_in_encl,
  input  logic [1:0]             req_acc,
  input  logic                   ent_valid,
  input  logic [PPN_W-IDX_W-1:0] ent_tag,
  input  logic [EID_W-1:0]       ent_owner,
  input  logic [VPN_W-1:0]       ent_vpn,
  input  logic [PERM_W-1:0]      ent_perm,
  input  logic [KIND_W-1:0]      ent_kind,
  output logic                   grant,
  output logic [2:0]             fault
);
  localparam logic [PPN_W:0] WIN_LO = (PPN_W+1)'(PROT_BASE);
  localparam logic [PPN_W:0] WIN_HI = (PPN_W+1)'(PROT_BASE + PROT_PAGES);

  logic in_win;
  logic hit;
  logic own_ok;
  logic va_ok;
  logic perm_ok;
  logic kind_ok;

  always_comb begin
    in_win = ({1'b0, req_ppn} >= WIN_LO) && ({1'b0, req_ppn} < WIN_HI);
    hit    = ent_valid && (ent_tag == req_ppn[PPN_W-1:IDX_W]);
    own_ok = req_in_encl && (ent_owner == req_eid);
    va_ok  = (ent_vpn == req_vpn);
    case (acc_e'(req_acc))
      ACC_RD:  perm_ok = ent_perm[0];
      ACC_WR:  perm_ok = ent_perm[1];
      ACC_EX:  perm_ok = ent_perm[2];
      default: perm_ok = 1'b0;
    endcase
    kind_ok = (ent_kind == KIND_REG);
  end

  always_comb begin
    if (!in_win)       fault = FLT_NONE;
    else if (!hit)     fault = FLT_INVAL;
    else if (!own_ok)  fault = FLT_OWNER;
    else if (!va_ok)   fault = FLT_VADDR;
    else if (!perm_ok) fault = FLT_PERM;
    else if (!kind_ok) fault = FLT_KIND;
    else               fault = FLT_NONE;
    grant = (fault == FLT_NONE);
  end
endmodule

// File: rtl/pg_own_check.sv
module pg_own_check
  import pgc_pkg::*;
#(
  parameter int PPN_W      = 8,
  parameter int VPN_W      = 8,
  parameter int EID_W      = 3,
  parameter int IDX_W      = 4,
  parameter int PROT_BASE  = 64,
  parameter int PROT_PAGES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PPN_W-1:0] req_ppn,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [EID_W-1:0] req_eid,
  input  logic             req_in_encl,
  input  logic [1:0]       req_priv,
  input  logic [1:0]       req_acc,
  input  logic             upd_en,
  input  logic [PPN_W-1:0] upd_ppn,
  input  logic             upd_valid,
  input  logic [EID_W-1:0] upd_owner,
  input  logic [VPN_W-1:0] upd_vpn,
  input  logic [2:0]       upd_perm,
  input  logic [1:0]       upd_ptype,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic [2:0]       rsp_fault
);
  localparam int TAG_W = PPN_W - IDX_W;

  logic             srst_n;
  logic             ent_valid;
  logic [TAG_W-1:0] ent_tag;
  logic [EID_W-1:0] ent_owner;
  logic [VPN_W-1:0] ent_vpn;
  logic [2:0]       ent_perm;
  logic [1:0]       ent_kind;
  logic             ev_grant;
  logic [2:0]       ev_fault;
  logic             priv_unused;

  // privilege level is carried for completeness but never weighs in the decision
  assign priv_unused = ^req_priv;

  pgc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pgc_table #(
    .PPN_W (PPN_W),
    .VPN_W (VPN_W),
    .EID_W (EID_W),
    .IDX_W (IDX_W)
  ) u_tab (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (upd_en),
    .wr_ppn   (upd_ppn),
    .wr_valid (upd_valid),
    .wr_owner (upd_owner),
    .wr_vpn   (upd_vpn),
    .wr_perm  (upd_perm),
    .wr_kind  (upd_ptype),
    .rd_ppn   (req_ppn),
    .rd_valid (ent_valid),
    .rd_tag   (ent_tag),
    .rd_owner (ent_owner),
    .rd_vpn   (ent_vpn),
    .rd_perm  (ent_perm),
    .rd_kind  (ent_kind)
  );

  pgc_eval #(
    .PPN_W      (PPN_W),
    .VPN_W      (VPN_W),
    .EID_W      (EID_W),
    .IDX_W      (IDX_W),
    .PROT_BASE  (PROT_BASE),
    .PROT_PAGES (PROT_PAGES)
  ) u_eval (
    .req_ppn     (req_ppn),
    .req_vpn     (req_vpn),
    .req_eid     (req_eid),
    .req_in_encl (req_in_encl),
    .req_acc     (req_acc),
    .ent_valid   (ent_valid),
    .ent_tag     (ent_tag),
    .ent_owner   (ent_owner),
    .ent_vpn     (ent_vpn),
    .ent_perm    (ent_perm),
    .ent_kind    (ent_kind),
    .grant       (ev_grant),
    .fault       (ev_fault)
  );

  logic       vld_q, vld_d;
  logic       grant_q, grant_d;
  logic [2:0] fault_q, fault_d;

  always_comb begin
    vld_d   = req_valid;
    grant_d = req_valid ? ev_grant : grant_q;
    fault_d = req_valid ? ev_fault : fault_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q   <= 1'b0;
      grant_q <= 1'b0;
      fault_q <= FLT_NONE;
    end else begin
      vld_q <= vld_d;
      if (req_valid) begin
        grant_q <= grant_d;
        fault_q <= fault_d;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_grant = grant_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk #(
  parameter int PPN_W      = 8,
  parameter int PROT_BASE  = 64,
  parameter int PROT_PAGES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [PPN_W-1:0] req_ppn,
  input logic             req_in_encl,
  input logic [1:0]       req_acc,
  input logic             rsp_valid,
  input logic             rsp_grant,
  input logic [2:0]       rsp_fault
);
  localparam logic [PPN_W:0] LO = (PPN_W+1)'(PROT_BASE);
  localparam logic [PPN_W:0] HI = (PPN_W+1)'(PROT_BASE + PROT_PAGES);

  logic prot;
  assign prot = ({1'b0, req_ppn} >= LO) && ({1'b0, req_ppn} < HI);

  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot) |=> (rsp_grant && rsp_fault == 3'd0));
  assert_outside_ctx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot && !req_in_encl) |=> (!rsp_grant && (rsp_fault == 3'd1 || rsp_fault == 3'd2)));
  assert_rsv_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot && req_acc == 2'b11) |=> !rsp_grant);
  assert_grant_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> rsp_fault == 3'd0);
  assert_fault_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> (rsp_fault >= 3'd1 && rsp_fault <= 3'd5));
endmodule

bind pg_own_check pgc_chk #(
  .PPN_W      (PPN_W),
  .PROT_BASE  (PROT_BASE),
  .PROT_PAGES (PROT_PAGES)
) u_chk (
  .clk         (clk),
  .rst_n       (srst_n),
  .req_valid   (req_valid),
  .req_ppn     (req_ppn),
  .req_in_encl (req_in_encl),
  .req_acc     (req_acc),
  .rsp_valid   (rsp_valid),
  .rsp_grant   (rsp_grant),
  .rsp_fault   (rsp_fault)
);

// File: tb/test_pg_own_check.sv
module test_pg_own_check;
  localparam int PPN_W = 8;
  localparam int VPN_W = 8;
  localparam int EID_W = 3;
  localparam int IDX_W = 4;
  localparam int BASE  = 64;
  localparam int PAGES = 32;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [PPN_W-1:0] req_ppn;
  logic [VPN_W-1:0] req_vpn;
  logic [EID_W-1:0] req_eid;
  logic             req_in_encl;
  logic [1:0]       req_priv;
  logic [1:0]       req_acc;
  logic             upd_en;
  logic [PPN_W-1:0] upd_ppn;
  logic             upd_valid;
  logic [EID_W-1:0] upd_owner;
  logic [VPN_W-1:0] upd_vpn;
  logic [2:0]       upd_perm;
  logic [1:0]       upd_ptype;
  logic             rsp_valid;
  logic             rsp_grant;
  logic [2:0]       rsp_fault;

  pg_own_check #(
    .PPN_W(PPN_W), .VPN_W(VPN_W), .EID_W(EID_W), .IDX_W(IDX_W),
    .PROT_BASE(BASE), .PROT_PAGES(PAGES)
  ) i_pg_own_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ppn(req_ppn),
    .req_vpn(req_vpn), .req_eid(req_eid), .req_in_encl(req_in_encl),
    .req_priv(req_priv), .req_acc(req_acc), .upd_en(upd_en), .upd_ppn(upd_ppn),
    .upd_valid(upd_valid), .upd_owner(upd_owner), .upd_vpn(upd_vpn),
    .upd_perm(upd_perm), .upd_ptype(upd_ptype), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference table built from the requirements
  bit                   m_vld   [DEPTH];
  logic [PPN_W-IDX_W-1:0] m_tag [DEPTH];
  logic [EID_W-1:0]     m_own   [DEPTH];
  logic [VPN_W-1:0]     m_vpn   [DEPTH];
  logic [2:0]           m_perm  [DEPTH];
  logic [1:0]           m_kind  [DEPTH];

  logic [3:0] exp_q [$];
  string      tag_q [$];

  function automatic logic [2:0] ref_code(logic [PPN_W-1:0] p, logic [VPN_W-1:0] v,
                                          logic [EID_W-1:0] e, logic ie, logic [1:0] a);
    int i;
    bit ok;
    if (int'(p) < BASE || int'(p) >= BASE + PAGES) return 3'd0;
    i = int'(p[IDX_W-1:0]);
    if (!m_vld[i] || m_tag[i] != p[PPN_W-1:IDX_W]) return 3'd1;
    if (!ie || m_own[i] != e) return 3'd2;
    if (m_vpn[i] != v) return 3'd3;
    ok = (a == 2'b00) ? m_perm[i][0] : (a == 2'b01) ? m_perm[i][1] :
         (a == 2'b10) ? m_perm[i][2] : 1'b0;
    if (!ok) return 3'd4;
    if (m_kind[i] != 2'b00) return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(bit cond, string rq, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic stage_req(logic [PPN_W-1:0] p, logic [VPN_W-1:0] v, logic [EID_W-1:0] e,
                           logic ie, logic [1:0] pr, logic [1:0] a, string rq);
    logic [2:0] c;
    req_valid = 1'b1; req_ppn = p; req_vpn = v; req_eid = e;
    req_in_encl = ie; req_priv = pr; req_acc = a;
    c = ref_code(p, v, e, ie, a);
    exp_q.push_back({(c == 3'd0), c});
    tag_q.push_back(rq);
  endtask

  task automatic stage_wr(logic [PPN_W-1:0] p, logic vl, logic [EID_W-1:0] o,
                          logic [VPN_W-1:0] v, logic [2:0] pm, logic [1:0] k);
    int i;
    upd_en = 1'b1; upd_ppn = p; upd_valid = vl; upd_owner = o;
    upd_vpn = v; upd_perm = pm; upd_ptype = k;
    i = int'(p[IDX_W-1:0]);
    m_vld[i] = vl; m_tag[i] = p[PPN_W-1:IDX_W]; m_own[i] = o;
    m_vpn[i] = v; m_perm[i] = pm; m_kind[i] = k;
  endtask

  task automatic req(logic [PPN_W-1:0] p, logic [VPN_W-1:0] v, logic [EID_W-1:0] e,
                     logic ie, logic [1:0] pr, logic [1:0] a, string rq);
    @(negedge clk);
    upd_en = 1'b0;
    stage_req(p, v, e, ie, pr, a, rq);
  endtask

  task automatic wr(logic [PPN_W-1:0] p, logic vl, logic [EID_W-1:0] o,
                    logic [VPN_W-1:0] v, logic [2:0] pm, logic [1:0] k);
    @(negedge clk);
    req_valid = 1'b0;
    stage_wr(p, vl, o, v, pm, k);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    upd_en    = 1'b0;
  endtask

  // monitor: pops expected items as results appear
  always begin
    @(posedge clk);
    #1;
    if (rst_n && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "result with nothing pending", 1, 0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_grant, rsp_fault} === e, t, "grant/fault",
              int'({rsp_grant, rsp_fault}), int'(e));
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; upd_en = 1'b0;
    req_ppn = '0; req_vpn = '0; req_eid = '0; req_in_encl = 1'b0;
    req_priv = 2'b00; req_acc = 2'b00; upd_ppn = '0; upd_valid = 1'b0;
    upd_owner = '0; upd_vpn = '0; upd_perm = '0; upd_ptype = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

    // R12: empty table after reset
    req(8'h45, 8'h12, 3'd3, 1'b1, 2'b00, 2'b00, "R12");
    req(8'h5F, 8'h00, 3'd0, 1'b1, 2'b11, 2'b00, "R12");
    // R2: window edges and far outside
    req(8'h3F, 8'h00, 3'd0, 1'b0, 2'b00, 2'b11, "R2");
    req(8'h60, 8'h01, 3'd1, 1'b0, 2'b00, 2'b10, "R2");
    req(8'h10, 8'h02, 3'd2, 1'b1, 2'b00, 2'b01, "R2");

    wr(8'h45, 1'b1, 3'd3, 8'h12, 3'b011, 2'b00);
    req(8'h45, 8'h12, 3'd3, 1'b1, 2'b00, 2'b00, "R9");
    req(8'h45, 8'h12, 3'd3, 1'b1, 2'b00, 2'b01, "R9");
    req(8'h45, 8'h12, 3'd3, 1'b1, 2'b00, 2'b10, "R6");
    req(8'h45, 8'h12, 3'd3, 1'b1, 2'b00, 2'b11, "R6");
    req(8'h45, 8'h12, 3'd2, 1'b1, 2'b00, 2'b00, "R4");
    req(8'h45, 8'h12, 3'd3, 1'b0, 2'b00, 2'b00, "R4");
    req(8'h45, 8'h12, 3'd2, 1'b1, 2'b11, 2'b00, "R10");
    req(8'h45, 8'h12, 3'd3, 1'b0, 2'b11, 2'b00, "R10");
    req(8'h45, 8'h13, 3'd3, 1'b1, 2'b00, 2'b00, "R5");
    req(8'h55, 8'h12, 3'd3, 1'b1, 2'b00, 2'b00, "R3");
    req(8'h45, 8'h13, 3'd2, 1'b1, 2'b00, 2'b10, "R8");
    req(8'h45, 8'h13, 3'd3, 1'b1, 2'b00, 2'b10, "R8");
    req(8'h55, 8'h13, 3'd2, 1'b0, 2'b00, 2'b11, "R8");

    wr(8'h46, 1'b1, 3'd5, 8'h20, 3'b111, 2'b01);
    wr(8'h47, 1'b1, 3'd5, 8'h21, 3'b111, 2'b10);
    wr(8'h48, 1'b1, 3'd5, 8'h22, 3'b111, 2'b11);
    wr(8'h49, 1'b1, 3'd5, 8'h23, 3'b000, 2'b10);
    req(8'h46, 8'h20, 3'd5, 1'b1, 2'b00, 2'b00, "R7");
    req(8'h47, 8'h21, 3'd5, 1'b1, 2'b00, 2'b01, "R7");
    req(8'h48, 8'h22, 3'd5, 1'b1, 2'b00, 2'b10, "R7");
    req(8'h49, 8'h23, 3'd5, 1'b1, 2'b00, 2'b00, "R8");
    req(8'h49, 8'h24, 3'd5, 1'b1, 2'b00, 2'b00, "R8");

    // R11: write and read the same slot in one cycle
    @(negedge clk);
    stage_req(8'h4A, 8'h30, 3'd1, 1'b1, 2'b00, 2'b00, "R11");
    stage_wr(8'h4A, 1'b1, 3'd1, 8'h30, 3'b001, 2'b00);
    req(8'h4A, 8'h30, 3'd1, 1'b1, 2'b00, 2'b00, "R11");
    // slot retag: page 0x5A replaces 0x4A in the same slot
    wr(8'h5A, 1'b1, 3'd1, 8'h30, 3'b001, 2'b00);
    req(8'h4A, 8'h30, 3'd1, 1'b1, 2'b00, 2'b00, "R3");
    req(8'h5A, 8'h30, 3'd1, 1'b1, 2'b00, 2'b00, "R11");
    // invalidate
    wr(8'h45, 1'b0, 3'd3, 8'h12, 3'b011, 2'b00);
    req(8'h45, 8'h12, 3'd3, 1'b1, 2'b00, 2'b00, "R3");

    // sweep every slot of the upper half of the window
    for (int i = 0; i < DEPTH; i++)
      wr(8'(8'h50 + i), 1'b1, 3'(i), 8'(i * 3), 3'b101, 2'b00);
    for (int i = 0; i < DEPTH; i++)
      req(8'(8'h50 + i), 8'(i * 3), 3'(i), 1'b1, 2'(i), 2'b10, "R9");
    for (int i = 0; i < DEPTH; i++)
      req(8'(8'h50 + i), 8'(i * 3), 3'(i), 1'b1, 2'b00, 2'b01, "R6");

    idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1", "responses outstanding", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule